// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out store for 9-bit words in which the producer and the consumer each run on their own clock. The clocks may be unrelated or may be the same net. Writes advance a write pointer in the write-clock domain. Reads move the oldest word into an output register in the read-clock domain. Each pointer crosses to the other domain as Gray code through a two-stage synchronizer, so each side sees a view of the other side's progress that is late but never optimistic.

Four active-low status outputs report the fill state: full and almost-full are timed by the write clock, and empty and almost-empty are timed by the read clock. A dual-purpose configuration pin is captured while reset is held. If it is captured high, the pin acts afterwards as a second, active-high write enable, which allows several FIFOs to share a write bus for depth expansion. If it is captured low, the block is in threshold mode. In that mode one write enable is enough, and the almost-full and almost-empty thresholds come from offset registers that a neighbouring sequencer loads through two strobe-and-value ports. An output-enable input stands in for a tri-state pad. It gates the output word and drives a data-valid flag.

Top module: `pf_dual_clk_fifo`

## Requirements
- R1: While rst is high, the block clears both pointers, clears the output register to zero and sets both offsets to 7. In the first cycle after reset, full_n and almost_full_n are 1 and empty_n and almost_empty_n are 0.
- R2: The block captures cfg_pin on every clock edge at which rst is high. A captured 1 selects dual-enable mode, and a captured 0 selects threshold mode. The mode holds until the next reset.
- R3: In dual-enable mode, a word is stored on a rising wclk only when wr_en1_n is 0 and cfg_pin is 1. A cfg_pin of 0 blocks the write.
- R4: In threshold mode, wr_en1_n equal to 0 alone stores a word, and cfg_pin has no effect on data writes.
- R5: The output register loads the next word on a rising rclk only when rd_en1_n and rd_en2_n are both 0. Otherwise it holds its value.
- R6: Words leave in the order they were written. This holds across pointer wrap-around.
- R7: After DEPTH words are stored and none are read, full_n goes to 0. While full_n is 0, write enables are ignored, and the FIFO never holds more than DEPTH words.
- R8: empty_n is 0 whenever no word is held. While empty_n is 0, read enables are ignored and the output register holds its value.
- R9: Once the pointers have settled, almost_empty_n is 0 exactly when the number of stored words is less than or equal to the empty offset.
- R10: Once the pointers have settled, almost_full_n is 0 exactly when the free space (DEPTH minus the number of words held) is less than or equal to the full offset.
- R11: In threshold mode, a pulse on ae_ofs_ld (read clock) or af_ofs_ld (write clock) loads the matching offset from its value port. In dual-enable mode these pulses are ignored.
- R12: When oe_n is 1, rd_data is 0 and rd_vld is 0. When oe_n is 0, rd_data shows the output register and rd_vld is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, seen by both domains |
| cfg_pin | input | 1 | Mode select while rst is high; second write enable in dual-enable mode |
| wr_en1_n | input | 1 | Active-low write enable |
| wr_data | input | 9 | Word to store |
| rd_en1_n | input | 1 | Active-low read enable, first of two |
| rd_en2_n | input | 1 | Active-low read enable, second of two |
| oe_n | input | 1 | Active-low output enable |
| ae_ofs_ld | input | 1 | Load strobe for the empty offset (read clock) |
| ae_ofs_val | input | AW | New empty offset |
| af_ofs_ld | input | 1 | Load strobe for the full offset (write clock) |
| af_ofs_val | input | AW | New full offset |
| rd_data | output | 9 | Output register, gated by oe_n |
| rd_vld | output | 1 | High when the output is enabled |
| full_n | output | 1 | Active-low full |
| almost_full_n | output | 1 | Active-low almost-full |
| empty_n | output | 1 | Active-low empty |
| almost_empty_n | output | 1 | Active-low almost-empty |

## Verification
The assertions check, on every edge of their own domain, the following properties. Both pointers and the flags take their reset values. The write pointer stays put while full is shown. The read pointer and the output register stay put while empty is shown or a read enable is high. The write side never sees more than DEPTH words outstanding, and empty never appears without almost-empty. The bench scenarios show the rest:

- data order through several wraps;
- the exact threshold boundaries once the pointers settle;
- the difference between the two write-enable modes;
- offset loads that are taken in one mode and ignored in the other;
- the output-enable gating.

The bench decides whether a write or read was accepted from the flags it samples before each edge. It then checks both that the accepted words come back in order and that the flags never claim room or data that does not exist.

// File: rtl/pf_fifo_pkg.sv
package pf_fifo_pkg;

    parameter int WORD_W   = 9;
    parameter int OFS_INIT = 7;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic {
        MODE_THRESH = 1'b0,
        MODE_DUALEN = 1'b1
    } pin_mode_e;

    typedef struct packed {
        logic full_n;
        logic afull_n;
    } wflags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rflags_t;

    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/pf_gray_sync.sv
module pf_gray_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pf_store.sv
module pf_store
    import pf_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    word_t cells [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/pf_wr_ctl.sv
module pf_wr_ctl
    import pf_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_pin,
    input  logic          wr_en1_n,
    input  logic [PW-1:0] rgray_s,
    input  logic          ofs_ld,
    input  logic [AW-1:0] ofs_val,
    output logic          wr_ok,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output wflags_t       flags
);
    logic          armed = 1'b0;
    pin_mode_e     mode_q;
    logic [AW-1:0] af_ofs;
    logic          en_ok;
    logic [PW-1:0] wbin_nx, rbin_seen, used_nx, free_nx;

    always_comb begin
        en_ok     = !wr_en1_n && (mode_q == MODE_THRESH || cfg_pin);
        wr_ok     = armed && !rst && flags.full_n && en_ok;
        wbin_nx   = wbin + PW'(wr_ok);
        rbin_seen = PW'(gray2bin(32'(rgray_s)));
        used_nx   = wbin_nx - rbin_seen;
        free_nx   = PW'(DEPTH) - used_nx;
    end

    // no write is possible before the first reset
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= pin_mode_e'(cfg_pin);
            wbin   <= '0;
            wgray  <= '0;
            af_ofs <= AW'(OFS_INIT);
            flags  <= '{full_n: 1'b1, afull_n: 1'b1};
        end else begin
            wbin          <= wbin_nx;
            wgray         <= PW'(bin2gray(32'(wbin_nx)));
            flags.full_n  <= (used_nx != PW'(DEPTH));
            flags.afull_n <= (free_nx > {1'b0, af_ofs});
            if (ofs_ld && mode_q == MODE_THRESH) af_ofs <= ofs_val;
        end
    end
endmodule

// File: rtl/pf_rd_ctl.sv
module pf_rd_ctl
    import pf_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_pin,
    input  logic          rd_en1_n,
    input  logic          rd_en2_n,
    input  logic [PW-1:0] wgray_s,
    input  word_t         mem_q,
    input  logic          ofs_ld,
    input  logic [AW-1:0] ofs_val,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output word_t         out_q,
    output rflags_t       flags
);
    pin_mode_e     mode_q;
    logic [AW-1:0] ae_ofs;
    logic          rd_ok;
    logic [PW-1:0] rbin_nx, wbin_seen, used_nx;

    always_comb begin
        rd_ok     = !rst && flags.empty_n && !rd_en1_n && !rd_en2_n;
        rbin_nx   = rbin + PW'(rd_ok);
        wbin_seen = PW'(gray2bin(32'(wgray_s)));
        used_nx   = wbin_seen - rbin_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= pin_mode_e'(cfg_pin);
            rbin   <= '0;
            rgray  <= '0;
            out_q  <= '0;
            ae_ofs <= AW'(OFS_INIT);
            flags  <= '{empty_n: 1'b0, aempty_n: 1'b0};
        end else begin
            rbin           <= rbin_nx;
            rgray          <= PW'(bin2gray(32'(rbin_nx)));
            flags.empty_n  <= (used_nx != '0);
            flags.aempty_n <= (used_nx > {1'b0, ae_ofs});
            if (rd_ok) out_q <= mem_q;
            if (ofs_ld && mode_q == MODE_THRESH) ae_ofs <= ofs_val;
        end
    end
endmodule

// File: rtl/pf_dual_clk_fifo.sv
module pf_dual_clk_fifo
    import pf_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              cfg_pin,
    input  logic              wr_en1_n,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic              oe_n,
    input  logic              ae_ofs_ld,
    input  logic [AW-1:0]     ae_ofs_val,
    input  logic              af_ofs_ld,
    input  logic [AW-1:0]     af_ofs_val,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_vld,
    output logic              full_n,
    output logic              almost_full_n,
    output logic              empty_n,
    output logic              almost_empty_n
);
    localparam int PW = AW + 1;

    logic [PW-1:0] wbin, wgray, rbin, rgray, wgray_r, rgray_w;
    logic          wr_ok;
    word_t         mem_q, out_q;
    wflags_t       wfl;
    rflags_t       rfl;

    pf_wr_ctl #(.DEPTH(DEPTH)) u_wr (
        .clk(wclk), .rst(rst), .cfg_pin(cfg_pin), .wr_en1_n(wr_en1_n),
        .rgray_s(rgray_w), .ofs_ld(af_ofs_ld), .ofs_val(af_ofs_val),
        .wr_ok(wr_ok), .wbin(wbin), .wgray(wgray), .flags(wfl)
    );

    pf_rd_ctl #(.DEPTH(DEPTH)) u_rd (
        .clk(rclk), .rst(rst), .cfg_pin(cfg_pin), .rd_en1_n(rd_en1_n),
        .rd_en2_n(rd_en2_n), .wgray_s(wgray_r), .mem_q(mem_q),
        .ofs_ld(ae_ofs_ld), .ofs_val(ae_ofs_val),
        .rbin(rbin), .rgray(rgray), .out_q(out_q), .flags(rfl)
    );

    pf_gray_sync #(.W(PW)) u_w2r (.clk(rclk), .rst(rst), .d(wgray), .q(wgray_r));
    pf_gray_sync #(.W(PW)) u_r2w (.clk(wclk), .rst(rst), .d(rgray), .q(rgray_w));

    pf_store #(.DEPTH(DEPTH)) u_mem (
        .wclk(wclk), .we(wr_ok), .waddr(wbin[AW-1:0]), .wdata(wr_data),
        .raddr(rbin[AW-1:0]), .rdata(mem_q)
    );

    assign rd_data        = oe_n ? '0 : out_q;
    assign rd_vld         = !oe_n;
    assign full_n         = wfl.full_n;
    assign almost_full_n  = wfl.afull_n;
    assign empty_n        = rfl.empty_n;
    assign almost_empty_n = rfl.aempty_n;
endmodule

// File: rtl/pf_dual_clk_fifo_chk.sv
module pf_dual_clk_fifo_chk
    import pf_fifo_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          rd_en1_n,
    input logic          rd_en2_n,
    input logic          full_n,
    input logic          almost_full_n,
    input logic          empty_n,
    input logic          almost_empty_n,
    input logic [PW-1:0] wbin,
    input logic [PW-1:0] rbin,
    input logic [PW-1:0] rgray_w,
    input word_t         out_q
);
    logic [PW-1:0] occ_w;
    assign occ_w = wbin - PW'(gray2bin(32'(rgray_w)));

    // R1
    wr_reset_chk: assert property (@(posedge wclk) disable iff (rst)
        $past(rst) |-> (full_n && almost_full_n && wbin == '0));

    // R1
    rd_reset_chk: assert property (@(posedge rclk) disable iff (rst)
        $past(rst) |-> (!empty_n && !almost_empty_n && rbin == '0 && out_q == '0));

    // R7
    full_hold_chk: assert property (@(posedge wclk) disable iff (rst)
        !full_n |=> $stable(wbin));

    // R8
    empty_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |=> ($stable(rbin) && $stable(out_q)));

    // R5
    read_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        (rd_en1_n || rd_en2_n) |=> ($stable(rbin) && $stable(out_q)));

    // R7
    no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
        occ_w <= PW'(DEPTH));

    // R9
    empty_implies_ae_chk: assert property (@(posedge rclk) disable iff (rst)
        !empty_n |-> !almost_empty_n);
endmodule

bind pf_dual_clk_fifo pf_dual_clk_fifo_chk #(.DEPTH(DEPTH)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n),
    .full_n(full_n), .almost_full_n(almost_full_n), .empty_n(empty_n),
    .almost_empty_n(almost_empty_n), .wbin(wbin), .rbin(rbin),
    .rgray_w(rgray_w), .out_q(out_q)
);

// File: tb/sim_pf_dual_clk_fifo.sv
module sim_pf_dual_clk_fifo;
    localparam int DEPTH = 32;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_pin = 1'b0, wr_en1_n = 1'b1, rd_en1_n = 1'b1, rd_en2_n = 1'b1;
    logic          oe_n = 1'b0, ae_ofs_ld = 1'b0, af_ofs_ld = 1'b0;
    logic [8:0]    wr_data = '0;
    logic [AW-1:0] ae_ofs_val = '0, af_ofs_val = '0;
    logic [8:0]    rd_data;
    logic          rd_vld, full_n, almost_full_n, empty_n, almost_empty_n;

    always #5 clk = ~clk;

    pf_dual_clk_fifo #(.DEPTH(DEPTH)) u0 (
        .wclk(clk), .rclk(clk), .rst(rst), .cfg_pin(cfg_pin), .wr_en1_n(wr_en1_n),
        .wr_data(wr_data), .rd_en1_n(rd_en1_n), .rd_en2_n(rd_en2_n), .oe_n(oe_n),
        .ae_ofs_ld(ae_ofs_ld), .ae_ofs_val(ae_ofs_val), .af_ofs_ld(af_ofs_ld),
        .af_ofs_val(af_ofs_val), .rd_data(rd_data), .rd_vld(rd_vld), .full_n(full_n),
        .almost_full_n(almost_full_n), .empty_n(empty_n), .almost_empty_n(almost_empty_n)
    );

    int         n_tests = 0, n_fail = 0;
    logic [8:0] q[$];
    logic [8:0] outv = '0;
    int         ae_m = 7, af_m = 7;
    bit         two_en = 1'b0;

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ae_n(input int n);
        return (n <= ae_m) ? 0 : 1;
    endfunction

    function automatic int exp_af_n(input int n);
        return ((DEPTH - n) <= af_m) ? 0 : 1;
    endfunction

    // one clock: drive at negedge, decide acceptance from sampled flags, check after edge
    task automatic cyc(input bit w, input bit pin, input bit r1, input bit r2,
                       input logic [8:0] d, input bit oe);
        bit acc_w, acc_r;
        wr_en1_n = !w; cfg_pin = pin; rd_en1_n = !r1; rd_en2_n = !r2;
        wr_data = d; oe_n = !oe;
        acc_w = w && (!two_en || pin) && full_n;
        acc_r = r1 && r2 && empty_n;
        @(posedge clk);
        @(negedge clk);
        if (acc_r) begin
            if (q.size() == 0) check("R8 read taken while empty", 1, 0);
            else outv = q.pop_front();
        end
        if (acc_w) q.push_back(d);
        if (q.size() > DEPTH) check("R7 overflow", q.size(), DEPTH);
        check("R6 output word", int'(rd_data), oe ? int'(outv) : 0);
        check("R12 valid flag", int'(rd_vld), int'(oe));
        if (q.size() == 0) check("R8 empty shown", int'(empty_n), 0);
        if (q.size() == DEPTH) check("R7 full shown", int'(full_n), 0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 1'b1);
    endtask

    task automatic settle_chk(input string ae_tag, input string af_tag);
        idle(5);
        check("R7 full after settle", int'(full_n), (q.size() == DEPTH) ? 0 : 1);
        check("R8 empty after settle", int'(empty_n), (q.size() == 0) ? 0 : 1);
        check(ae_tag, int'(almost_empty_n), exp_ae_n(q.size()));
        check(af_tag, int'(almost_full_n), exp_af_n(q.size()));
    endtask

    task automatic do_reset(input bit pin);
        rst = 1'b1; cfg_pin = pin; wr_en1_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        oe_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; cfg_pin = 1'b0;
        q.delete(); outv = '0; ae_m = 7; af_m = 7; two_en = pin;
        check("R1 full_n after reset", int'(full_n), 1);
        check("R1 almost_full_n after reset", int'(almost_full_n), 1);
        check("R1 empty_n after reset", int'(empty_n), 0);
        check("R1 almost_empty_n after reset", int'(almost_empty_n), 0);
        check("R1 output register cleared", int'(rd_data), 0);
    endtask

    task automatic fill_to(input int t, input bit pin);
        for (int i = 0; i < 4 * DEPTH && q.size() < t; i++)
            cyc(1'b1, pin, 1'b0, 1'b0, 9'($urandom), 1'b1);
    endtask

    task automatic drain_to(input int t);
        for (int i = 0; i < 4 * DEPTH && q.size() > t; i++)
            cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 1'b1);
    endtask

    task automatic load_ofs(input bit ae, input logic [AW-1:0] v);
        if (ae) begin ae_ofs_ld = 1'b1; ae_ofs_val = v; end
        else    begin af_ofs_ld = 1'b1; af_ofs_val = v; end
        idle(1);
        ae_ofs_ld = 1'b0; af_ofs_ld = 1'b0;
        if (!two_en) begin
            if (ae) ae_m = int'(v); else af_m = int'(v);
        end
    endtask

    initial begin
        void'($urandom(32'd20240607));
        // R2: pin low during reset selects threshold mode
        do_reset(1'b0);
        settle_chk("R1 default empty offset", "R1 default full offset");
        // R4: cfg_pin low or high, one enable writes
        for (int i = 0; i < 7; i++) cyc(1'b1, i[0], 1'b0, 1'b0, 9'(i + 100), 1'b1);
        check("R4 words stored in threshold mode", q.size(), 7);
        settle_chk("R9 count equals empty offset", "R10 low fill");
        fill_to(8, 1'b0);
        settle_chk("R9 count one above offset", "R10 low fill");
        fill_to(24, 1'b0);
        settle_chk("R9 mid", "R10 free one above offset");
        fill_to(25, 1'b0);
        settle_chk("R9 mid", "R10 free equals offset");
        for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h1AA, 1'b1);
        check("R7 writes ignored when full", q.size(), DEPTH);
        settle_chk("R9 full", "R10 full");
        // R5: only one read enable low -> hold
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b0, 9'd0, 1'b1);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, 1'b1, 9'd0, 1'b1);
        check("R5 no read with one enable high", q.size(), DEPTH);
        drain_to(0);
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 1'b1);
        check("R8 reads ignored when empty", q.size(), 0);
        settle_chk("R9 empty", "R10 empty");
        // R11: offsets loaded in threshold mode
        load_ofs(1'b1, AW'(3));
        load_ofs(1'b0, AW'(2));
        fill_to(3, 1'b0);
        settle_chk("R11 empty offset 3 at count 3", "R11 full offset low fill");
        fill_to(4, 1'b0);
        settle_chk("R11 empty offset 3 at count 4", "R11 full offset low fill");
        fill_to(29, 1'b0);
        settle_chk("R11 high fill", "R11 full offset 2 free 3");
        fill_to(30, 1'b0);
        settle_chk("R11 high fill", "R11 full offset 2 free 2");
        drain_to(0);
        // R6: random traffic with wrap
        for (int i = 0; i < 3000; i++) begin
            cyc(bit'($urandom % 2), bit'($urandom % 2), bit'(($urandom % 4) != 0),
                bit'(($urandom % 4) != 0), 9'($urandom), bit'(($urandom % 8) != 0));
            if (i % 250 == 249) settle_chk("R9 random settle", "R10 random settle");
        end
        // R2: pin high during reset selects dual-enable mode
        do_reset(1'b1);
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 9'h055, 1'b1);
        settle_chk("R3 blocked write leaves empty", "R3 blocked write");
        check("R3 second enable low blocks write", q.size(), 0);
        for (int i = 0; i < 5; i++) cyc(1'b1, 1'b1, 1'b0, 1'b0, 9'(i + 7), 1'b1);
        check("R3 both enables write", q.size(), 5);
        load_ofs(1'b1, AW'(2));
        settle_chk("R11 offset load ignored in dual-enable mode", "R10 dual-enable");
        // R12: output disabled
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1, 1'b1, 9'd0, 1'b0);
        cyc(1'b0, 1'b0, 1'b0, 1'b0, 9'd0, 1'b1);
        drain_to(0);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog run did not finish actual=0 expected=1");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule